// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block owns the exception-related fields of a floating-point status register: a per-flag trap-enable mask, a sticky accrued field, a current field for the last completed operation, and a trap-type code. Each time an arithmetic unit finishes an operation, it presents a five-bit raw exception vector with a one-cycle strobe. The block then decides whether the operation must trap, and it rewrites the status fields to match that decision.

On a trap, the enabled flags are narrowed to one bit by fixed priority, and the sticky field is left as it was. On a normal completion, the raw flags become the current field and are also merged into the sticky field. In both cases the block raises exactly one registered outcome pulse: a trap request or an advance-to-next-instruction pulse. Software can overwrite the whole register through a write port.

Top module: `fp_exc_status`

## Requirements
- R1: A synchronous active-high reset clears the whole status register and both outcome pulses.
- R2: The fields sit at these positions: trap-enable mask at bits 27:23, accrued field at 9:5, current field at 4:0, and trap type at 16:14. Within each five-bit field the flag order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: An operation traps when its raw flags ANDed with the enable mask are nonzero. In that case `trap_req` is high for the one cycle after the strobe.
- R4: On a trap, the current field becomes only the highest-priority enabled flag. The priority order is invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R5: On a trap, the accrued field keeps its value and the trap-type field becomes 1.
- R6: Without a trap, the current field is replaced by the raw flags, so an operation with no flags clears it. The accrued field is ORed with the raw flags, and the trap type is kept.
- R7: Without a trap, `advance` is high for the one cycle after the strobe. Each strobe yields exactly one of `trap_req` and `advance`, never both.
- R8: A software write loads the full register on the next edge and wins over an operation completing in the same cycle. That operation still produces its outcome pulse, decided with the enable mask held before the write.
- R9: With no strobe, neither pulse is raised. An update never alters bits outside the four fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | One-cycle strobe: an operation has completed |
| op_flags | input | 5 | Raw exception flags of that operation |
| sw_we | input | 1 | Software write enable for the status register |
| sw_wdata | input | 32 | Value for a software write |
| status_q | output | 32 | Current status register contents |
| trap_req | output | 1 | Registered trap request pulse |
| trap_type | output | 3 | Trap-type field of the register |
| advance | output | 1 | Registered pulse: continue with the next instruction |

## Verification
A software write and an operation completion can land on the same edge. The bench provokes this by raising `sw_we` and `op_done` together, twice. The first time, the old mask enables the flag, so a trap is expected. The second time, the old mask enables nothing, so an advance is expected. Both cases are judged the same way: the register must equal the written word, and the pulse must be the one given by the mask held before the write.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  // Field geometry of the status register; neighbours decode these positions.
  localparam int FLAG_W   = 5;
  localparam int TT_W     = 3;
  localparam int MASK_LSB = 23;
  localparam int ACC_LSB  = 5;
  localparam int CUR_LSB  = 0;
  localparam int TT_LSB   = 14;

  // Trap-type code reported for an IEEE exception trap.
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
endpackage

// File: rtl/fpx_prio_pick.sv
// Keeps only the most significant set bit; the flag order puts invalid on top.
module fpx_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);
  assign pick[W-1] = req[W-1];
  for (genvar i = 0; i < W-1; i++) begin : g_bit
    assign pick[i] = req[i] & ~(|req[W-1:i+1]);
  end
endmodule

// File: rtl/fpx_exc_next.sv
// Computes the trap decision and the next register value for one completed operation.
module fpx_exc_next
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0]  cur_reg,
  input  logic [FLAG_W-1:0] flags,
  output logic [REG_W-1:0]  nxt_reg,
  output logic              trap
);
  logic [FLAG_W-1:0] enabled;
  logic [FLAG_W-1:0] single;

  assign enabled = flags & cur_reg[MASK_LSB +: FLAG_W];
  assign trap    = |enabled;

  fpx_prio_pick #(.W(FLAG_W)) u_pick (
    .req  (enabled),
    .pick (single)
  );

  always_comb begin
    nxt_reg = cur_reg;
    if (trap) begin
      nxt_reg[CUR_LSB +: FLAG_W] = single;
      nxt_reg[TT_LSB +: TT_W]    = TT_IEEE;
    end else begin
      nxt_reg[CUR_LSB +: FLAG_W] = flags;
      nxt_reg[ACC_LSB +: FLAG_W] = cur_reg[ACC_LSB +: FLAG_W] | flags;
    end
  end
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_done,
  input  logic [FLAG_W-1:0] op_flags,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  status_q,
  output logic              trap_req,
  output logic [TT_W-1:0]   trap_type,
  output logic              advance
);
  logic [REG_W-1:0] upd_reg;
  logic             upd_trap;

  fpx_exc_next #(.REG_W(REG_W)) u_next (
    .cur_reg (status_q),
    .flags   (op_flags),
    .nxt_reg (upd_reg),
    .trap    (upd_trap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      trap_req <= 1'b0;
      advance  <= 1'b0;
    end else begin
      if (sw_we)        status_q <= sw_wdata;
      else if (op_done) status_q <= upd_reg;
      trap_req <= op_done & upd_trap;
      advance  <= op_done & ~upd_trap;
    end
  end

  assign trap_type = status_q[TT_LSB +: TT_W];

  // R7: at most one outcome at a time
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !advance);

  // R7: each strobe gives exactly one outcome
  a_r7_one_per_op: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_done)) |-> (trap_req ^ advance));

  // R9: no pulse without a strobe
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_done)) |-> (!trap_req && !advance));

  // R4: a trap leaves a single current flag
  a_r4_single_flag: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !$past(sw_we)) |-> ($countones(status_q[CUR_LSB +: FLAG_W]) == 1));

  // R5: a trap keeps the accrued field and sets the trap type
  a_r5_acc_kept: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !$past(sw_we)) |->
      (status_q[ACC_LSB +: FLAG_W] == $past(status_q[ACC_LSB +: FLAG_W]) && trap_type == TT_IEEE));

  // R8: software write wins
  a_r8_sw_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_we)) |-> (status_q == $past(sw_wdata)));
endmodule

// File: tb/test_fp_exc_status.sv
module test_fp_exc_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] status_q;
  logic        trap_req;
  logic [2:0]  trap_type;
  logic        advance;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_exc_status i_fp_exc_status (
    .clk(clk), .rst(rst), .op_done(op_done), .op_flags(op_flags),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status_q(status_q),
    .trap_req(trap_req), .trap_type(trap_type), .advance(advance)
  );

  // {mask, accrued before, raw flags, expected current, expected accrued, expected trap}
  localparam logic [25:0] VEC [8] = '{
    {5'b00000, 5'b00000, 5'b10101, 5'b10101, 5'b10101, 1'b0},
    {5'b00000, 5'b01010, 5'b00001, 5'b00001, 5'b01011, 1'b0},
    {5'b11111, 5'b00011, 5'b11000, 5'b10000, 5'b00011, 1'b1},
    {5'b00111, 5'b00000, 5'b01110, 5'b00100, 5'b00000, 1'b1},
    {5'b00001, 5'b00000, 5'b00001, 5'b00001, 5'b00000, 1'b1},
    {5'b10000, 5'b00100, 5'b01111, 5'b01111, 5'b01111, 1'b0},
    {5'b01010, 5'b00000, 5'b11011, 5'b01000, 5'b00000, 1'b1},
    {5'b11111, 5'b10001, 5'b00000, 5'b00000, 5'b10001, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [4:0] m, input logic [2:0] tt,
                                     input logic [4:0] acc, input logic [4:0] cur);
    return 32'h8000_0000 | (32'(m) << 23) | (32'(tt) << 14) | (32'(acc) << 5) | 32'(cur);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 status", status_q, 32'h0);
    check("R1 trap_req", {31'd0, trap_req}, 32'd0);
    check("R1 advance", {31'd0, advance}, 32'd0);
    rst = 1'b0;

    // Table walk: R2..R7, R9
    foreach (VEC[k]) begin
      logic [4:0] m, a0, fl, ecur, eacc;
      logic       etrap;
      {m, a0, fl, ecur, eacc, etrap} = VEC[k];
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = mk(m, 3'b110, a0, 5'b11111);
      @(negedge clk);
      sw_we = 1'b0;
      op_done = 1'b1; op_flags = fl;
      @(negedge clk);
      op_done = 1'b0; op_flags = '0;
      check(etrap ? "R4 R5 status after trap" : "R6 status after normal op",
            status_q, mk(m, etrap ? 3'b001 : 3'b110, eacc, ecur));
      check("R3 trap_req", {31'd0, trap_req}, {31'd0, etrap});
      check("R7 advance", {31'd0, advance}, {31'd0, ~etrap});
      @(negedge clk);
      check("R9 trap_req idle", {31'd0, trap_req}, 32'd0);
      check("R9 advance idle", {31'd0, advance}, 32'd0);
    end

    // R8: collision with the old mask fully enabled, so a trap is expected
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = mk(5'b11111, 3'b000, 5'b00000, 5'b00000);
    @(negedge clk);
    sw_wdata = 32'h0000_0123; op_done = 1'b1; op_flags = 5'b00001;
    @(negedge clk);
    sw_we = 1'b0; op_done = 1'b0; op_flags = '0;
    check("R8 write wins over trap", status_q, 32'h0000_0123);
    check("R8 trap from old mask", {31'd0, trap_req}, 32'd1);
    check("R8 no advance", {31'd0, advance}, 32'd0);

    // R8: collision with the old mask empty, so an advance is expected
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = mk(5'b11111, 3'b000, 5'b00000, 5'b00000);
    op_done = 1'b1; op_flags = 5'b00001;
    @(negedge clk);
    sw_we = 1'b0; op_done = 1'b0; op_flags = '0;
    check("R8 write wins over normal op", status_q, mk(5'b11111, 3'b000, 5'b00000, 5'b00000));
    check("R8 advance from old mask", {31'd0, advance}, 32'd1);
    check("R8 no trap", {31'd0, trap_req}, 32'd0);

    // R1: reset clears a loaded register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears loaded register", status_q, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule